// File: doc/BRIEF.md
# GPIO Bank with Masked Half-Word Writes

This block is one 32-pin general-purpose I/O bank on a plain 32-bit register bus. It stores an output data word, a per-pin direction word and a per-pin driver-enable word. From these it drives the pad output values and the pad drive enables. It also passes the pad inputs through a two-flop synchronizer, so that software can read the pin levels.

Each 16-bit half of the output data word has its own masked-write register. In such a write, the upper 16 bits are active-low per-bit masks and the lower 16 bits carry the new values. Software can therefore change any subset of pins atomically, with no read-modify-write sequence. A full-word data register writes all 32 output bits at once.

The bus is a plain register port. A write takes effect at the clock edge where `bus_we` is high. `bus_rdata` follows `bus_addr` combinationally. There is no handshake and no back-pressure: every access completes in one cycle.

Top module: `gpio_bank_masked`

## Requirements
- R1: After reset, the output data, direction and driver-enable words are all 0. `pad_out` and `pad_oe` are therefore 0, and every pin is an undriven input.
- R2: A write to the low-half masked register at byte address 0x00 updates data bit i (0..15) to wdata[i] only where wdata[16+i] is 0. Data bits where the mask bit is 1, and all of bits 31:16, keep their value.
- R3: A write to the high-half masked register at byte address 0x04 updates data bit 16+i to wdata[i] only where wdata[16+i] is 0. Data bits where the mask bit is 1, and all of bits 15:0, keep their value.
- R4: A masked write whose bits 31:16 are all 1 (for example 0xFFFF0000 or 0xFFFF1234) changes no data bit.
- R5: A write to the full data register at byte address 0x08 replaces all 32 data bits. Reading that address returns the data word, and `pad_out` equals the data word from the clock edge of the write onward.
- R6: Reading the pin view at byte address 0x0C returns `pad_in` as it was two rising clock edges earlier. Writes to this address change nothing.
- R7: The direction register (byte address 0x10, 1 = output) and the driver-enable register (byte address 0x14, 1 = drive) are each written whole and read back unchanged.
- R8: `pad_oe[i]` is 1 exactly when direction bit i and driver-enable bit i are both 1.
- R9: Reading a masked register returns the data bits of its half in bits 15:0 and zeros in bits 31:16.
- R10: Any other address reads as 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pin levels from the pads (asynchronous) |
| pad_out | output | 32 | Output value for each pad |
| pad_oe | output | 32 | Pad driver enable, 1 = driven, 0 = high impedance |

## Verification
The masked merge is tried with three kinds of mask on each half:
- A mixed mask, which shows whether the kept and the replaced bits are chosen per bit and not per half.
- An all-ones mask, with zero data and with non-zero data, which shows that the mask alone suppresses the write.
- A write to one half, followed by a readback of the other half, which shows that the halves are independent.

A full-word write before and after the masked writes tells the full path apart from the merge paths. Direction and driver-enable patterns that overlap only partly show that the pad enable needs both bits. A step on `pad_in` read after one edge and again after two edges measures the synchronizer depth exactly.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int GPB_ADDR_W = 8;
  localparam int GPB_DATA_W = 32;
  localparam int GPB_HALF_W = GPB_DATA_W / 2;
  localparam int GPB_NHALF  = 2;

  localparam logic [GPB_ADDR_W-1:0] OFS_HALF_LO = 8'h00;
  localparam logic [GPB_ADDR_W-1:0] OFS_HALF_HI = 8'h04;
  localparam logic [GPB_ADDR_W-1:0] OFS_FULL    = 8'h08;
  localparam logic [GPB_ADDR_W-1:0] OFS_PINS    = 8'h0C;
  localparam logic [GPB_ADDR_W-1:0] OFS_DIR     = 8'h10;
  localparam logic [GPB_ADDR_W-1:0] OFS_DRV     = 8'h14;

  typedef enum logic [2:0] {
    SEL_HALF_LO,
    SEL_HALF_HI,
    SEL_FULL,
    SEL_PINS,
    SEL_DIR,
    SEL_DRV,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
  import gpb_pkg::*;
(
  input  logic [GPB_ADDR_W-1:0] addr_i,
  output reg_sel_e              sel_o
);
  always_comb begin
    unique case (addr_i)
      OFS_HALF_LO: sel_o = SEL_HALF_LO;
      OFS_HALF_HI: sel_o = SEL_HALF_HI;
      OFS_FULL:    sel_o = SEL_FULL;
      OFS_PINS:    sel_o = SEL_PINS;
      OFS_DIR:     sel_o = SEL_DIR;
      OFS_DRV:     sel_o = SEL_DRV;
      default:     sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic             warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= async_i;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_q[s-1];
        end
      end

      p_stage_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> stage_q[s] == $past(stage_q[s-1]))
        else $error("p_stage_shift_r6");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm_q <= 1'b0;
    end else begin
      warm_q <= 1'b1;
    end
  end

  p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> stage_q[0] == $past(async_i))
    else $error("p_first_stage_r6");

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
  import gpb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  reg_sel_e              sel_i,
  input  logic [GPB_DATA_W-1:0] wdata_i,
  output logic [GPB_DATA_W-1:0] data_o,
  output logic [GPB_DATA_W-1:0] dir_o,
  output logic [GPB_DATA_W-1:0] drv_o
);
  logic [GPB_DATA_W-1:0] data_q, dir_q, drv_q, data_nxt;
  logic [GPB_HALF_W-1:0] keep_m, new_v;

  assign keep_m = wdata_i[GPB_DATA_W-1:GPB_HALF_W];
  assign new_v  = wdata_i[GPB_HALF_W-1:0];

  generate
    for (genvar h = 0; h < GPB_NHALF; h++) begin : g_half
      localparam reg_sel_e MY_SEL = (h == 0) ? SEL_HALF_LO : SEL_HALF_HI;
      logic hit;
      assign hit = we_i && (sel_i == MY_SEL);
      always_comb begin
        if (we_i && sel_i == SEL_FULL) begin
          data_nxt[h*GPB_HALF_W +: GPB_HALF_W] = wdata_i[h*GPB_HALF_W +: GPB_HALF_W];
        end else if (hit) begin
          data_nxt[h*GPB_HALF_W +: GPB_HALF_W] =
            (data_q[h*GPB_HALF_W +: GPB_HALF_W] & keep_m) | (new_v & ~keep_m);
        end else begin
          data_nxt[h*GPB_HALF_W +: GPB_HALF_W] = data_q[h*GPB_HALF_W +: GPB_HALF_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else begin
      data_q <= data_nxt;
      if (we_i && sel_i == SEL_DIR) dir_q <= wdata_i;
      if (we_i && sel_i == SEL_DRV) drv_q <= wdata_i;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign drv_o  = drv_q;

  p_lo_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_HALF_LO) |=>
      ((data_q[GPB_HALF_W-1:0] & $past(keep_m)) == ($past(data_q[GPB_HALF_W-1:0]) & $past(keep_m)))
      && $stable(data_q[GPB_DATA_W-1:GPB_HALF_W]))
    else $error("p_lo_keep_r2");

  p_hi_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_HALF_HI) |=>
      ((data_q[GPB_DATA_W-1:GPB_HALF_W] & $past(keep_m)) == ($past(data_q[GPB_DATA_W-1:GPB_HALF_W]) & $past(keep_m)))
      && $stable(data_q[GPB_HALF_W-1:0]))
    else $error("p_hi_keep_r3");

  p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (sel_i == SEL_HALF_LO || sel_i == SEL_HALF_HI) && (&keep_m)) |=> $stable(data_q))
    else $error("p_all_masked_r4");

  p_full_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_FULL) |=> data_q == $past(wdata_i))
    else $error("p_full_write_r5");

  p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_DIR) |=> dir_q == $past(wdata_i))
    else $error("p_dir_write_r7");

  p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (sel_i == SEL_NONE || sel_i == SEL_PINS)) |=>
      $stable(data_q) && $stable(dir_q) && $stable(drv_q))
    else $error("p_stray_write_r10");
endmodule

// File: rtl/gpb_pad_ctrl.sv
module gpb_pad_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] drv_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      assign pad_out_o[p] = data_i[p];
      assign pad_oe_o[p]  = dir_i[p] & drv_i[p];
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_masked.sv
module gpio_bank_masked
  import gpb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GPB_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [GPB_DATA_W-1:0] bus_wdata,
  output logic [GPB_DATA_W-1:0] bus_rdata,
  input  logic [GPB_DATA_W-1:0] pad_in,
  output logic [GPB_DATA_W-1:0] pad_out,
  output logic [GPB_DATA_W-1:0] pad_oe
);
  reg_sel_e              sel;
  logic [GPB_DATA_W-1:0] data_w, dir_w, drv_w, pins_w;

  gpb_decode u_decode (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  gpb_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we),
    .sel_i   (sel),
    .wdata_i (bus_wdata),
    .data_o  (data_w),
    .dir_o   (dir_w),
    .drv_o   (drv_w)
  );

  gpb_sync #(.WIDTH(GPB_DATA_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_in),
    .sync_o  (pins_w)
  );

  gpb_pad_ctrl #(.WIDTH(GPB_DATA_W)) u_pads (
    .data_i    (data_w),
    .dir_i     (dir_w),
    .drv_i     (drv_w),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe)
  );

  always_comb begin
    unique case (sel)
      SEL_HALF_LO: bus_rdata = {{GPB_HALF_W{1'b0}}, data_w[GPB_HALF_W-1:0]};
      SEL_HALF_HI: bus_rdata = {{GPB_HALF_W{1'b0}}, data_w[GPB_DATA_W-1:GPB_HALF_W]};
      SEL_FULL:    bus_rdata = data_w;
      SEL_PINS:    bus_rdata = pins_w;
      SEL_DIR:     bus_rdata = dir_w;
      SEL_DRV:     bus_rdata = drv_w;
      default:     bus_rdata = '0;
    endcase
  end

  p_oe_needs_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_DIR && bus_wdata == '0) |=> pad_oe == '0)
    else $error("p_oe_needs_both_r8");

  p_half_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HALF_LO || sel == SEL_HALF_HI) |-> bus_rdata[GPB_DATA_W-1:GPB_HALF_W] == '0)
    else $error("p_half_read_r9");
endmodule

// File: tb/gpio_bank_masked_tb_top.sv
module gpio_bank_masked_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_data = '0;
  logic [31:0] exp_dir = '0;
  logic [31:0] exp_drv = '0;

  always #10 clk = ~clk;

  gpio_bank_masked dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    merge = (old & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  task automatic t_reset;
    logic [31:0] r;
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    bus_read(8'h08, r); check("R1 data", r, 32'h0);
    bus_read(8'h10, r); check("R1 dir", r, 32'h0);
    bus_read(8'h14, r); check("R1 drv", r, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] r;
    bus_write(8'h08, 32'hA5A5_3C3C); exp_data = 32'hA5A5_3C3C;
    bus_read(8'h08, r); check("R5 readback", r, exp_data);
    check("R5 pad_out", pad_out, exp_data);
  endtask

  task automatic t_lo_mask;
    logic [31:0] r;
    bus_write(8'h00, 32'hFF00_1234);
    exp_data[15:0] = merge(exp_data[15:0], 32'hFF00_1234);
    check("R2 pad_out mixed mask", pad_out, exp_data);
    bus_write(8'h00, 32'h5555_FFFF);
    exp_data[15:0] = merge(exp_data[15:0], 32'h5555_FFFF);
    check("R2 pad_out alt mask", pad_out, exp_data);
    bus_read(8'h04, r); check("R2 high half untouched", r, {16'h0, exp_data[31:16]});
  endtask

  task automatic t_hi_mask;
    logic [31:0] r;
    bus_write(8'h04, 32'h0F0F_0000);
    exp_data[31:16] = merge(exp_data[31:16], 32'h0F0F_0000);
    check("R3 pad_out mixed mask", pad_out, exp_data);
    bus_read(8'h00, r); check("R3 low half untouched", r, {16'h0, exp_data[15:0]});
    bus_read(8'h08, r); check("R3 full readback", r, exp_data);
  endtask

  task automatic t_all_mask;
    bus_write(8'h00, 32'hFFFF_0000); check("R4 lo all masked", pad_out, exp_data);
    bus_write(8'h04, 32'hFFFF_1234); check("R4 hi all masked", pad_out, exp_data);
  endtask

  task automatic t_half_read;
    logic [31:0] r;
    bus_write(8'h08, 32'hDEAD_BEEF); exp_data = 32'hDEAD_BEEF;
    bus_read(8'h00, r); check("R9 lo read", r, 32'h0000_BEEF);
    bus_read(8'h04, r); check("R9 hi read", r, 32'h0000_DEAD);
  endtask

  task automatic t_dir_drv;
    logic [31:0] r;
    bus_write(8'h10, 32'hF0F0_F0F0); exp_dir = 32'hF0F0_F0F0;
    check("R8 dir only no drive", pad_oe, 32'h0);
    bus_write(8'h14, 32'hFF00_FF00); exp_drv = 32'hFF00_FF00;
    bus_read(8'h10, r); check("R7 dir readback", r, exp_dir);
    bus_read(8'h14, r); check("R7 drv readback", r, exp_drv);
    check("R8 pad_oe overlap", pad_oe, exp_dir & exp_drv);
  endtask

  task automatic t_sync;
    logic [31:0] r;
    @(negedge clk); pad_in = 32'h1357_9BDF; bus_addr = 8'h0C;
    @(negedge clk); #2; check("R6 one edge old", bus_rdata, 32'h0);
    @(negedge clk); #2; check("R6 two edges new", bus_rdata, 32'h1357_9BDF);
    bus_write(8'h0C, 32'h0000_0000);
    bus_read(8'h0C, r); check("R6 view write ignored", r, 32'h1357_9BDF);
    bus_read(8'h08, r); check("R6 data untouched", r, exp_data);
  endtask

  task automatic t_unmapped;
    logic [31:0] r;
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, r); check("R10 unmapped reads zero", r, 32'h0);
    bus_read(8'h08, r); check("R10 data untouched", r, exp_data);
    check("R10 pad_oe untouched", pad_oe, exp_dir & exp_drv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_full;
    t_lo_mask;
    t_hi_mask;
    t_all_mask;
    t_half_read;
    t_dir_drv;
    t_sync;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule